// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Sticky Error Status

This block recovers characters from an asynchronous serial line. It uses a clock enable that pulses sixteen times per bit period. Each frame has a start bit, then either 7 or 8 data bits sent least significant bit first, then an optional parity bit (even or odd), then one or two stop bits. The format is selected by static configuration inputs. A received character lands in a data register. A small status register reports three things: a character is ready, the stop bit was wrong, or the parity did not match.

Software uses a simple register bus. Address 0 is the status register and address 1 is the data register. To clear a flag, software must first read the flag as 1 and then write 0 to it. An error flag that is set freezes the receiver, so no new frames start until software has cleared it. Turning off receive enable stops reception but leaves the error flags as they are.

Top module: `serial_rx_core`

## Requirements
- R1: Data bits are sampled LSB first at bit centres. The data register (address 1) holds the last received character. In 7-bit mode, bit 7 of that value reads 0. The data register changes only when a frame completes.
- R2: A frame with no error sets the ready flag (status bit 0) in the same step that the data register is updated.
- R3: When parity is enabled, status bit 2 sets if the count of 1s over the data bits plus the parity bit is odd with even parity selected, or even with odd parity selected. With parity disabled, this bit never sets.
- R4: Status bit 1 sets when the first stop bit is sampled as 0. When status bit 1 or bit 2 is set for a frame, the character is still written to the data register, but the ready flag is not set.
- R5: In two-stop-bit mode, the value of the second stop bit has no effect on the error flags.
- R6: No new frame is received while status bit 1 or bit 2 is 1, or while receive enable is low.
- R7: A status flag clears only when software writes 0 to its bit and the previous status read returned that bit as 1. Any write to the status register consumes that read mark. Writing 1 to a bit has no effect on it.
- R8: Driving receive enable low leaves both error flags unchanged.
- R9: After reset, all status flags are 0 and the data register is 0.
- R10: A start bit is accepted only after the line has been seen high and then falls, and only if the line is still low 8 ticks after the fall. Otherwise the receiver returns to waiting for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_in | input | 1 | Serial line, idles high |
| rx_en | input | 1 | Receive enable |
| cfg_short | input | 1 | 1 = 7 data bits, 0 = 8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | Two stop bits |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = status, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational; 0 when not reading |

## Verification
The hardest state to reach is a flag that is set, has been read as 1, and then has its read mark spent by a write of 1s. The next write of 0 must then leave the flag set. The bench gets there by first forcing a parity error, then reading status, writing 0xFF, and writing 0. A second hard case is a frame whose second stop bit is driven low. The bench checks that this frame still completes cleanly and that the low level does not start a false frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP1, RX_STOP2
  } rx_state_e;

  localparam int unsigned FLAG_N   = 3;
  localparam int unsigned FLAG_RDY = 0;
  localparam int unsigned FLAG_FER = 1;
  localparam int unsigned FLAG_PER = 2;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], d_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign d_out = sync_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVS    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              en,
  input  logic              blocked,
  input  logic              cfg_short,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  output logic              done,
  output logic              fer,
  output logic              per,
  output logic              busy,
  output logic [DATA_W-1:0] data
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned BW  = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e          st_q, st_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [BW-1:0]      bidx_q, bidx_d;
  logic [DATA_W-1:0]  sh_q, sh_d;
  logic               pacc_q, pacc_d;
  logic               pbad_q, pbad_d;
  logic               hi_q, hi_d;
  logic               done_q, done_d;
  logic               fer_q, fer_d;
  logic               per_q, per_d;
  logic [BW-1:0]      nbits;

  always_comb nbits = cfg_short ? BW'(DATA_W - 1) : BW'(DATA_W);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bidx_d = bidx_q;
    sh_d   = sh_q;
    pacc_d = pacc_q;
    pbad_d = pbad_q;
    hi_d   = hi_q;
    done_d = 1'b0;
    fer_d  = fer_q;
    per_d  = per_q;
    if (!en) begin
      st_d = RX_IDLE;
      hi_d = 1'b0;
    end else if (tick) begin
      case (st_q)
        RX_IDLE: begin
          if (line) hi_d = 1'b1;
          else if (hi_q && !blocked) begin
            st_d  = RX_START;
            cnt_d = '0;
            hi_d  = 1'b0;
          end
        end
        RX_START: begin
          if (cnt_q == MID) begin
            cnt_d = '0;
            if (!line) begin
              st_d   = RX_DATA;
              bidx_d = '0;
              pacc_d = 1'b0;
              pbad_d = 1'b0;
            end else begin
              st_d = RX_IDLE;
              hi_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == LAST) begin
            cnt_d  = '0;
            sh_d   = {line, sh_q[DATA_W-1:1]};
            pacc_d = pacc_q ^ line;
            if (bidx_q == nbits - BW'(1)) st_d = cfg_par_en ? RX_PAR : RX_STOP1;
            else                          bidx_d = bidx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (cnt_q == LAST) begin
            cnt_d  = '0;
            pbad_d = pacc_q ^ line ^ cfg_par_odd;
            st_d   = RX_STOP1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP1: begin
          if (cnt_q == LAST) begin
            cnt_d  = '0;
            done_d = 1'b1;
            fer_d  = !line;
            per_d  = cfg_par_en & pbad_q;
            st_d   = cfg_two_stop ? RX_STOP2 : RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP2: begin
          if (cnt_q == LAST) begin
            cnt_d = '0;
            st_d  = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      pacc_q <= 1'b0;
      pbad_q <= 1'b0;
      hi_q   <= 1'b0;
      done_q <= 1'b0;
      fer_q  <= 1'b0;
      per_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bidx_q <= bidx_d;
      sh_q   <= sh_d;
      pacc_q <= pacc_d;
      pbad_q <= pbad_d;
      hi_q   <= hi_d;
      done_q <= done_d;
      fer_q  <= fer_d;
      per_q  <= per_d;
    end
  end

  assign done = done_q;
  assign fer  = fer_q;
  assign per  = per_q;
  assign busy = (st_q != RX_IDLE);
  assign data = cfg_short ? {1'b0, sh_q[DATA_W-1:1]} : sh_q;
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              fer_in,
  input  logic              per_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              rd_stat,
  input  logic              wr_stat,
  input  logic [FLAG_N-1:0] wbits,
  output logic [FLAG_N-1:0] flags,
  output logic [DATA_W-1:0] data
);
  logic [FLAG_N-1:0] flag_q, flag_d;
  logic [FLAG_N-1:0] mark_q, mark_d;
  logic [FLAG_N-1:0] set_ev;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    set_ev           = '0;
    set_ev[FLAG_RDY] = done & ~fer_in & ~per_in;
    set_ev[FLAG_FER] = done & fer_in;
    set_ev[FLAG_PER] = done & per_in;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    logic clr;
    always_comb begin
      clr       = wr_stat & mark_q[i] & ~wbits[i];
      flag_d[i] = set_ev[i] | (flag_q[i] & ~clr);
      if (rd_stat)      mark_d[i] = flag_q[i];
      else if (wr_stat) mark_d[i] = 1'b0;
      else              mark_d[i] = mark_q[i];
    end
  end

  always_comb data_d = done ? data_in : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mark_q <= '0;
      data_q <= '0;
    end else begin
      flag_q <= flag_d;
      mark_q <= mark_d;
      data_q <= data_d;
    end
  end

  assign flags = flag_q;
  assign data  = data_q;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_in,
  input  logic              rx_en,
  input  logic              cfg_short,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              line_s;
  logic              rx_done, rx_fer, rx_per, rx_busy;
  logic [DATA_W-1:0] rx_data;
  logic [FLAG_N-1:0] flags;
  logic [DATA_W-1:0] reg_data;
  logic              rd_stat, wr_stat;
  logic              flag_rdy, flag_fer, flag_per;
  logic              unused_wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    rd_stat = bus_sel & ~bus_wr & ~bus_addr;
    wr_stat = bus_sel &  bus_wr & ~bus_addr;
  end

  assign flag_rdy     = flags[FLAG_RDY];
  assign flag_fer     = flags[FLAG_FER];
  assign flag_per     = flags[FLAG_PER];
  assign unused_wbits = ^bus_wdata[DATA_W-1:FLAG_N];

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_in(rx_in), .d_out(line_s)
  );

  rx_frame_fsm #(.OVS(OVS), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .tick(os_tick), .line(line_s),
    .en(rx_en), .blocked(flag_fer | flag_per),
    .cfg_short(cfg_short), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .done(rx_done), .fer(rx_fer), .per(rx_per), .busy(rx_busy),
    .data(rx_data)
  );

  rx_status_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .done(rx_done), .fer_in(rx_fer),
    .per_in(rx_per), .data_in(rx_data), .rd_stat(rd_stat),
    .wr_stat(wr_stat), .wbits(bus_wdata[FLAG_N-1:0]),
    .flags(flags), .data(reg_data)
  );

  always_comb begin
    if (bus_sel && !bus_wr)
      bus_rdata = bus_addr ? reg_data : {{(DATA_W-FLAG_N){1'b0}}, flags};
    else
      bus_rdata = '0;
  end
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              cfg_par_en,
  input logic              rx_done,
  input logic              rx_fer,
  input logic              rx_per,
  input logic              rx_busy,
  input logic              flag_rdy,
  input logic              flag_fer,
  input logic              flag_per,
  input logic              wr_stat,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] reg_data
);
  AST_DATA_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |=> $stable(reg_data)); // R1
  AST_NO_PARITY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !cfg_par_en |-> !rx_per); // R3
  AST_ERR_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && (rx_fer || rx_per) && !flag_rdy |=> !flag_rdy); // R4
  AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_fer || flag_per) && !rx_busy |=> !rx_busy); // R6
  AST_FER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_fer && !(wr_stat && !bus_wdata[1]) |=> flag_fer); // R7
  AST_PER_HELD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && flag_per && !wr_stat |=> flag_per); // R8
endmodule

bind serial_rx_core serial_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_par_en(cfg_par_en),
  .rx_done(rx_done), .rx_fer(rx_fer), .rx_per(rx_per), .rx_busy(rx_busy),
  .flag_rdy(flag_rdy), .flag_fer(flag_fer), .flag_per(flag_per),
  .wr_stat(wr_stat), .bus_wdata(bus_wdata), .reg_data(reg_data)
);

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int BIT_CLKS   = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rx_in = 1'b1;
  logic       rx_en = 1'b1;
  logic       cfg_short = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // behavioural reference state
  bit       m_rdy, m_fer, m_per;
  bit [2:0] m_mark;
  bit [7:0] m_data;

  serial_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in), .rx_en(rx_en),
    .cfg_short(cfg_short), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk) os_tick = 1'b1;
      @(negedge clk) os_tick = 1'b0;
      repeat (TDIV - 2) @(negedge clk);
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input bit addr, input string req);
    logic [7:0] exp;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
    #1;
    exp = addr ? m_data : {5'b0, m_per, m_fer, m_rdy};
    check(req, bus_rdata, exp);
    if (!addr) m_mark = {m_per, m_fer, m_rdy};
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = v;
    if (m_mark[0] && !v[0]) m_rdy = 1'b0;
    if (m_mark[1] && !v[1]) m_fer = 1'b0;
    if (m_mark[2] && !v[2]) m_per = 1'b0;
    m_mark = 3'b000;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic line_bit(input bit b);
    rx_in = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit par_bad, input bit stop1, input bit stop2);
    int  nb;
    logic [7:0] dm;
    bit  p;
    nb = cfg_short ? 7 : 8;
    dm = cfg_short ? (d & 8'h7F) : d;
    p  = (^dm) ^ cfg_par_odd ^ par_bad;
    @(negedge clk);
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(dm[i]);
    if (cfg_par_en) line_bit(p);
    line_bit(stop1);
    if (cfg_two_stop) line_bit(stop2);
    line_bit(1'b1);
    line_bit(1'b1);
    if (rx_en && !m_fer && !m_per) begin
      m_data = dm;
      if (!stop1) m_fer = 1'b1;
      if (cfg_par_en && par_bad) m_per = 1'b1;
      if (stop1 && !(cfg_par_en && par_bad)) m_rdy = 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_rdy = 0; m_fer = 0; m_per = 0; m_mark = 0; m_data = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    rd(1'b0, "R9 status after reset");
    rd(1'b1, "R9 data after reset");

    send(8'hA5, 0, 1, 1);
    rd(1'b1, "R1 8N1 data");
    rd(1'b0, "R2 ready set");
    wr(8'h00);
    rd(1'b0, "R7 ready cleared after read");

    send(8'h3C, 0, 1, 1);
    wr(8'h00);
    rd(1'b0, "R7 ready kept without prior read");
    wr(8'h00);
    rd(1'b0, "R7 ready cleared");

    cfg_short = 1; cfg_par_en = 1; cfg_par_odd = 0;
    send(8'hD3, 0, 1, 1);
    rd(1'b1, "R1 7-bit data top bit zero");
    rd(1'b0, "R3 even parity ok");
    wr(8'h00);

    cfg_short = 0; cfg_par_odd = 1;
    send(8'h5A, 1, 1, 1);
    rd(1'b0, "R3 odd parity error");
    rd(1'b1, "R4 data stored on parity error");

    send(8'h11, 0, 1, 1);
    rd(1'b1, "R6 frame ignored while error set");
    wr(8'hFF);
    wr(8'h00);
    rd(1'b0, "R7 write of 1 consumes mark");
    wr(8'h00);
    rd(1'b0, "R7 parity flag cleared");

    cfg_par_en = 0;
    send(8'h81, 0, 0, 1);
    rd(1'b0, "R4 framing error");
    rd(1'b1, "R4 data stored on framing error");

    rx_en = 0;
    repeat (50) @(negedge clk);
    rd(1'b0, "R8 flag held while disabled");
    wr(8'h00);
    send(8'h77, 0, 1, 1);
    rd(1'b1, "R6 frame ignored while disabled");
    rd(1'b0, "R6 no flag while disabled");
    rx_en = 1;
    repeat (BIT_CLKS) @(negedge clk);

    cfg_par_en = 1; cfg_par_odd = 0; cfg_two_stop = 1;
    send(8'h96, 0, 1, 0);
    rd(1'b0, "R5 second stop ignored");
    rd(1'b1, "R5 data two-stop");
    wr(8'h00);
    rd(1'b0, "R5 no false start after low stop2");
    cfg_two_stop = 0; cfg_par_en = 0;

    @(negedge clk);
    rx_in = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rx_in = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    rd(1'b0, "R10 short start rejected");
    rd(1'b1, "R10 data unchanged after glitch");
    send(8'h42, 0, 1, 1);
    rd(1'b1, "R10 reception resumes after glitch");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule